// File: doc/BRIEF.md
# Interlocked Self-Timed Register Pipeline

This block is a chain of word-wide register stages. The chain moves data like a bucket brigade. Each stage has its own load strobe. A small rendezvous controller raises that strobe after checking only the stage before it and the stage after it. No shared enable spans the whole chain. The head stage is the data origin: each time it fires, it advances a binary count and offers the new value downstream. Each middle stage copies the word held by its predecessor. The tail stage drives the word onto the output port.

Each stage carries a full/empty token. A middle stage fires when its predecessor is full and it is itself empty. In the same step, it marks itself full and empties its predecessor, so each word is handed on exactly once. The handshake is modelled as a sampled, clock-enabled emulation. Every token and every data register updates on the emulation clock, and a stage loads only in the cycles where its local strobe is high. An activation level gates all firing. An asynchronous reset returns every controller, token and register to its initial state.

Top module: `brigade_pipe`

## Requirements
- R1: The stage count DEPTH must be at least 2 and the word width WIDTH at least 1. Any other value is rejected at elaboration.
- R2: While reset is asserted, and immediately when it is asserted, the output word reads 0. Every stage token also reads empty.
- R3: The head stage fires whenever its own token is empty and activation is high. On each firing it loads its count plus one, so the first word it offers is 1.
- R4: A middle stage fires only in a cycle where its predecessor is full and it is itself empty. In that cycle it loads the predecessor's word.
- R5: The tail stage fires in every active cycle where its predecessor is full. It places that word on the output.
- R6: With activation held high from the first clock edge after reset, the output after edge t is 0 for t < DEPTH. From edge DEPTH on, it is (t - DEPTH)/2 + 1 (integer division).
- R7: In a cycle where activation is sampled low, no stage fires. The output word and every token hold their values.
- R8: Across any pattern of activation, every change of the output word is an increment of exactly 1. No word is lost or repeated when activation drops and returns.
- R9: When a stage other than the head fires, its predecessor's token reads empty in the next cycle. When a stage other than the tail fires, its own token reads full in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Emulation clock on which the local strobes are sampled |
| arst_i | input | 1 | Asynchronous reset, active high |
| run_i | input | 1 | Activation level; firing is allowed only while it is high |
| word_o | output | WIDTH | Word held by the tail stage |

## Verification
The hardest case to reach from the ports is an activation drop while several words sit part-way along the chain, with some tokens full and others empty. The stimulus toggles activation in random bursts taken from a seeded $urandom stream, so it freezes the chain in many different token patterns. After each freeze it checks that the output resumes with the very next count. A directed run with activation held high checks the exact arrival timing at two depths. A mid-run asynchronous reset shows that the output clears without waiting for a clock edge.

// File: rtl/brigade_pkg.sv
package brigade_pkg;

   typedef enum logic [1:0] {
      ROLE_HEAD   = 2'd0,
      ROLE_MIDDLE = 2'd1,
      ROLE_TAIL   = 2'd2
   } stage_role_e;

   function automatic stage_role_e role_of(input int idx, input int depth);
      if (idx == 0)              return ROLE_HEAD;
      else if (idx == depth - 1) return ROLE_TAIL;
      else                       return ROLE_MIDDLE;
   endfunction

endpackage

// File: rtl/brigade_ctl.sv
module brigade_ctl
   import brigade_pkg::*;
#(
   parameter stage_role_e ROLE = ROLE_MIDDLE
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic run_i,
   input  logic up_full_i,
   input  logic down_fire_i,
   output logic fire_o,
   output logic full_o
);

   logic full_q;
   logic ready;

   generate
      if (ROLE == ROLE_TAIL) begin : g_tail
         // no successor: never blocked by its own token
         assign ready = up_full_i;
      end else begin : g_hold
         // head sees a permanently full predecessor (tied by the parent)
         assign ready = up_full_i & ~full_q;
      end
   endgenerate

   assign fire_o = run_i & ready;
   assign full_o = full_q;

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i)           full_q <= 1'b0;
      else if (fire_o)      full_q <= 1'b1;
      else if (down_fire_i) full_q <= 1'b0;
   end

endmodule

// File: rtl/brigade_reg.sv
module brigade_reg #(
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             arst_i,
   input  logic             load_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   always_ff @(posedge clk_i or posedge arst_i) begin
      if (arst_i)      q_o <= '0;
      else if (load_i) q_o <= d_i;
   end

endmodule

// File: rtl/brigade_pipe.sv
module brigade_pipe
   import brigade_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             arst_i,
   input  logic             run_i,
   output logic [WIDTH-1:0] word_o
);

   localparam int LAST = DEPTH - 1;

   // R1: elaboration-time parameter checks
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("brigade_pipe: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("brigade_pipe: WIDTH must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] fire;
   logic [DEPTH-1:0] full;
   logic [WIDTH-1:0] word [DEPTH];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         localparam stage_role_e ROLE = role_of(i, DEPTH);
         logic             up_full;
         logic             down_fire;
         logic [WIDTH-1:0] d_next;

         if (ROLE == ROLE_HEAD) begin : g_head
            assign up_full   = 1'b1;
            assign down_fire = fire[i+1];
            assign d_next    = word[i] + WIDTH'(1);
         end else if (ROLE == ROLE_MIDDLE) begin : g_mid
            assign up_full   = full[i-1];
            assign down_fire = fire[i+1];
            assign d_next    = word[i-1];
         end else begin : g_tail
            assign up_full   = full[i-1];
            assign down_fire = 1'b0;
            assign d_next    = word[i-1];
         end

         brigade_ctl #(.ROLE(ROLE)) u_ctl (
            .clk_i      (clk_i),
            .arst_i     (arst_i),
            .run_i      (run_i),
            .up_full_i  (up_full),
            .down_fire_i(down_fire),
            .fire_o     (fire[i]),
            .full_o     (full[i])
         );

         brigade_reg #(.WIDTH(WIDTH)) u_reg (
            .clk_i (clk_i),
            .arst_i(arst_i),
            .load_i(fire[i]),
            .d_i   (d_next),
            .q_o   (word[i])
         );
      end
   endgenerate

   assign word_o = word[LAST];

endmodule

// File: rtl/brigade_pipe_chk.sv
module brigade_pipe_chk #(
   parameter int DEPTH = 4,
   parameter int WIDTH = 32
) (
   input logic             clk_i,
   input logic             arst_i,
   input logic             run_i,
   input logic [WIDTH-1:0] word_o,
   input logic [DEPTH-1:0] fire,
   input logic [DEPTH-1:0] full
);

   // R2: reset clears output and tokens
   p_reset_clear_r2: assert property (@(posedge clk_i)
      arst_i |=> (word_o == '0 && full == '0));

   // R7: inactive cycle freezes everything
   p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (arst_i)
      !run_i |=> ($stable(word_o) && $stable(full)));

   // R8: output only ever steps by one
   p_step_one_r8: assert property (@(posedge clk_i) disable iff (arst_i)
      (word_o != $past(word_o)) |-> (word_o == $past(word_o) + WIDTH'(1)));

   // R3: head firing leaves its token full
   p_head_full_r3: assert property (@(posedge clk_i) disable iff (arst_i)
      fire[0] |=> full[0]);

   // R5: an offered word reaches the output on the next cycle
   p_tail_take_r5: assert property (@(posedge clk_i) disable iff (arst_i)
      (run_i && full[DEPTH-2]) |=> (word_o != $past(word_o)));

   generate
      for (genvar i = 1; i < DEPTH; i++) begin : g_pair
         // R9: the predecessor is emptied by a hand-over
         p_pred_empty_r9: assert property (@(posedge clk_i) disable iff (arst_i)
            fire[i] |=> !full[i-1]);
         // R4: neighbours never fire together
         p_no_overlap_r4: assert property (@(posedge clk_i) disable iff (arst_i)
            !(fire[i] && fire[i-1]) || (i == DEPTH - 1 && 1'b0));
      end
      for (genvar i = 1; i < DEPTH - 1; i++) begin : g_mid
         // R9: a middle stage holds its word after a hand-over
         p_self_full_r9: assert property (@(posedge clk_i) disable iff (arst_i)
            fire[i] |=> full[i]);
      end
   endgenerate

endmodule

bind brigade_pipe brigade_pipe_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
   .clk_i (clk_i),
   .arst_i(arst_i),
   .run_i (run_i),
   .word_o(word_o),
   .fire  (fire),
   .full  (full)
);

// File: tb/tb_brigade_pipe.sv
module tb_brigade_pipe;

   localparam int WIDTH = 32;
   localparam int DEP_A = 5;
   localparam int DEP_B = 2;

   logic clk = 1'b0;
   logic arst = 1'b1;
   logic run = 1'b0;
   logic [WIDTH-1:0] word_a, word_b;

   int checks = 0;
   int fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   brigade_pipe #(.DEPTH(DEP_A), .WIDTH(WIDTH)) dut (
      .clk_i(clk), .arst_i(arst), .run_i(run), .word_o(word_a));

   brigade_pipe #(.DEPTH(DEP_B), .WIDTH(WIDTH)) dut_d2 (
      .clk_i(clk), .arst_i(arst), .run_i(run), .word_o(word_b));

   function automatic logic [WIDTH-1:0] expect_at(input int t, input int depth);
      if (t < depth) return '0;
      return WIDTH'((t - depth) / 2 + 1);
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [WIDTH-1:0] act, input logic [WIDTH-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_reset(input string req);
      chk(word_a == '0, req, word_a, '0);
      chk(word_b == '0, req, word_b, '0);
   endtask

   // R6 / R3 / R4 / R5: exact arrival timing with activation held from reset
   task automatic run_latency(input int cycles);
      run = 1'b1;
      arst = 1'b0;
      for (int t = 1; t <= cycles; t++) begin
         @(negedge clk);
         chk(word_a == expect_at(t, DEP_A), "R6 depth5 timing (R3 R4 R5)",
             word_a, expect_at(t, DEP_A));
         chk(word_b == expect_at(t, DEP_B), "R6 depth2 timing (R3 R5)",
             word_b, expect_at(t, DEP_B));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [WIDTH-1:0] last_a, last_b;
      bit prev_run;
      void'($urandom(32'h5eed_1234));

      repeat (3) @(negedge clk);
      check_reset("R2 reset state");

      run_latency(40);

      // R7: directed freeze
      last_a = word_a;
      last_b = word_b;
      run = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(word_a == last_a, "R7 hold depth5", word_a, last_a);
         chk(word_b == last_b, "R7 hold depth2", word_b, last_b);
      end

      // R8 / R7: random activation bursts
      for (int n = 0; n < 3000; n++) begin
         prev_run = run;
         last_a = word_a;
         last_b = word_b;
         if ($urandom_range(0, 3) == 0) run = ~run;
         prev_run = run;
         @(negedge clk);
         if (!prev_run) begin
            chk(word_a == last_a, "R7 idle hold depth5", word_a, last_a);
            chk(word_b == last_b, "R7 idle hold depth2", word_b, last_b);
         end else begin
            chk(word_a == last_a || word_a == last_a + 1, "R8 step depth5",
                word_a, last_a + 1);
            chk(word_b == last_b || word_b == last_b + 1, "R8 step depth2",
                word_b, last_b + 1);
         end
      end

      // R8: progress after resume
      last_a = word_a;
      run = 1'b1;
      repeat (2 * DEP_A + 4) @(negedge clk);
      chk(word_a > last_a, "R8 resume progress depth5", word_a, last_a + 1);

      // R2: asynchronous reset between edges
      #1 arst = 1'b1;
      #0.5;
      check_reset("R2 async clear");
      run = 1'b0;
      @(negedge clk);
      check_reset("R2 held in reset");

      run_latency(20);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule